// File: doc/BRIEF.md
# Fractional Slot-Mask Baud Generator

This block derives the timing pulses of an asynchronous serial port from a fast reference clock. Every bit time is split into sixteen sub-bit periods. Each sub-bit period lasts a whole number of reference clocks, set by an integer divisor. A 16-bit slot mask then picks which sub-bit periods are lengthened by one extra clock. This gives a non-integer clock-to-baud ratio without an accumulator. The block emits a one-clock oversample pulse at the end of each sub-bit period and a one-clock bit pulse at the end of the sixteenth. It also reports the index of the sub-bit period in progress.

Software can load the slot mask directly. It can also select a plain-fraction mode, in which a 4-bit remainder is written and a built-in helper converts it into an evenly spread mask. The divisor, the mask and the mode are sampled into shadow registers only while the generator is idle or at a bit boundary. A reprogram therefore never distorts a bit that is already in flight.

Top module: `baud_slot_gen`

## Requirements
- R1: With divisor register value D and effective mask M, each bit time spans exactly 16*(D+1) + popcount(M) reference clocks, measured from one bit pulse to the next.
- R2: Sub-bit period i (0..15) spans D+1 clocks, plus one more when bit i of M is 1.
- R3: `os_tick` is high for exactly one clock, the last clock of each sub-bit period. `slot_idx` shows the index of the period in progress, steps by one after every `os_tick`, and wraps from 15 to 0.
- R4: `bit_tick` is high only together with the `os_tick` that ends sub-bit period 15.
- R5: With `frac_mode`=1 the effective mask is derived from `frac_val` and `slot_mask` is ignored. The values, given as fraction:mask in hex, are 0:0000, 1:0080, 2:0808, 3:0888, 4:2222, 5:4924, 6:4a52, 7:54aa, 8:5555, 9:d555, 10:d5d5, 11:ddd5, 12:dddd, 13:dfdd, 14:dfdf and 15:ffdf.
- R6: With `frac_mode`=0 the effective mask is `slot_mask` and `frac_val` has no effect.
- R7: A change of `div_int`, `slot_mask`, `frac_mode` or `frac_val` while running leaves the current bit time unchanged. The new values govern the bit time that starts after the next `bit_tick`.
- R8: While `en` is 0, no tick is produced and `slot_idx` is 0 from the clock after `en` falls. Configuration is captured on every idle clock. The first bit after `en` rises uses the values present on the last idle clock and starts at slot 0 with a full-length period.
- R9: While `rst_n` is 0 at a clock edge, the counters clear and no tick is produced. After release, with `en` high, timing starts at slot 0 using the configuration present during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable |
| div_int | input | DIV_W | Integer divisor: sub-bit period minus one |
| slot_mask | input | 16 | Stretch mask, bit i lengthens sub-bit period i |
| frac_mode | input | 1 | 1: derive mask from frac_val, 0: use slot_mask |
| frac_val | input | 4 | Plain fractional remainder 0..15 |
| os_tick | output | 1 | Oversample pulse, end of each sub-bit period |
| bit_tick | output | 1 | Bit pulse, end of sub-bit period 15 |
| slot_idx | output | 4 | Index of the sub-bit period in progress |

## Verification
A wrong sub-bit counter or a wrong mask bit shows up at the very next `os_tick`: that pulse arrives one clock early or late, and the bench measures every interval against D+1+M[i]. A slot index that skips or repeats makes the reported `slot_idx` disagree with the bench's own count at that same pulse, and it puts `bit_tick` on the wrong pulse within one bit time. A shadow register that loads at the wrong moment lengthens or shortens the bit time during which a reprogram happens, so it is visible within one bit.

// File: rtl/baud_pkg.sv
// Package baud_pkg
// Shared constants for the slot-mask baud generator, and the function that
// turns a 4-bit remainder into an evenly spread 16-bit stretch mask.
// Assumes exactly sixteen sub-bit periods per bit.
package baud_pkg;
    localparam int NSLOT  = 16;
    localparam int SLOT_W = $clog2(NSLOT);

    typedef logic [NSLOT-1:0] slot_mask_t;

    // Spread pattern per remainder, so that popcount equals the remainder
    function automatic slot_mask_t spread_mask(input logic [SLOT_W-1:0] frac);
        slot_mask_t m;
        case (frac)
            4'd0:    m = 16'h0000;
            4'd1:    m = 16'h0080;
            4'd2:    m = 16'h0808;
            4'd3:    m = 16'h0888;
            4'd4:    m = 16'h2222;
            4'd5:    m = 16'h4924;
            4'd6:    m = 16'h4a52;
            4'd7:    m = 16'h54aa;
            4'd8:    m = 16'h5555;
            4'd9:    m = 16'hd555;
            4'd10:   m = 16'hd5d5;
            4'd11:   m = 16'hddd5;
            4'd12:   m = 16'hdddd;
            4'd13:   m = 16'hdfdd;
            4'd14:   m = 16'hdfdf;
            default: m = 16'hffdf;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/baud_frac_mask.sv
// Module baud_frac_mask
// Selects the effective stretch mask: the raw slot mask, or the spread
// pattern built from a plain 4-bit remainder. Purely combinational.
module baud_frac_mask
    import baud_pkg::*;
(
    input  logic              frac_mode,
    input  slot_mask_t        slot_mask,
    input  logic [SLOT_W-1:0] frac_val,
    output slot_mask_t        eff_mask
);
    // Mode mux between the direct mask and the helper pattern
    always_comb begin
        if (frac_mode) eff_mask = spread_mask(frac_val);
        else           eff_mask = slot_mask;
    end
endmodule

// File: rtl/baud_cfg_shadow.sv
// Module baud_cfg_shadow
// Holds the divisor and mask that govern the bit in progress. It follows
// the live inputs on every idle clock (reset or disabled) and otherwise
// reloads only at a bit boundary.
module baud_cfg_shadow
    import baud_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             bit_end,
    input  logic [DIV_W-1:0] div_in,
    input  slot_mask_t       mask_in,
    output logic [DIV_W-1:0] div_q,
    output slot_mask_t       mask_q
);
    logic load;

    // Load strobe: idle clocks and bit boundaries
    always_comb load = !rst_n || !en || bit_end;

    // Shadow registers, captured on the load strobe
    always_ff @(posedge clk) begin
        if (load) begin
            div_q  <= div_in;
            mask_q <= mask_in;
        end
    end
endmodule

// File: rtl/baud_tick_core.sv
// Module baud_tick_core
// Counts reference clocks within a sub-bit period and sub-bit periods within
// a bit. It assumes that the divisor and mask inputs are stable for a whole bit.
module baud_tick_core
    import baud_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DIV_W-1:0]  div_q,
    input  slot_mask_t        mask_q,
    output logic              os_tick,
    output logic              bit_tick,
    output logic [SLOT_W-1:0] slot_idx
);
    localparam int CNT_W = DIV_W + 1;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NSLOT - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  limit;
    logic [SLOT_W-1:0] slot_q;
    logic              period_end;

    // Terminal count for the current sub-bit period, including any stretch
    always_comb limit = {1'b0, div_q} + CNT_W'(mask_q[slot_q]);

    // End of a sub-bit period, qualified by run state
    always_comb period_end = rst_n && en && (cnt_q == limit);

    // Clock and slot counters, held at zero while idle
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q  <= '0;
            slot_q <= '0;
        end else if (cnt_q == limit) begin
            cnt_q  <= '0;
            slot_q <= slot_q + 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Output pulses and slot index
    always_comb begin
        os_tick  = period_end;
        bit_tick = period_end && (slot_q == LAST_SLOT);
        slot_idx = slot_q;
    end
endmodule

// File: rtl/baud_slot_gen.sv
// Module baud_slot_gen (top)
// Fractional baud generator: 16 sub-bit periods per bit, each D+1 clocks
// plus one if its mask bit is set. It assumes a single clock domain and
// synchronous active-low reset. Configuration is taken while idle or at
// a bit boundary.
module baud_slot_gen
    import baud_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DIV_W-1:0]  div_int,
    input  logic [NSLOT-1:0]  slot_mask,
    input  logic              frac_mode,
    input  logic [SLOT_W-1:0] frac_val,
    output logic              os_tick,
    output logic              bit_tick,
    output logic [SLOT_W-1:0] slot_idx
);
    slot_mask_t       eff_mask;
    slot_mask_t       mask_q;
    logic [DIV_W-1:0] div_q;

    baud_frac_mask u_mask (
        .frac_mode (frac_mode),
        .slot_mask (slot_mask),
        .frac_val  (frac_val),
        .eff_mask  (eff_mask)
    );

    baud_cfg_shadow #(.DIV_W(DIV_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .bit_end (bit_tick),
        .div_in  (div_int),
        .mask_in (eff_mask),
        .div_q   (div_q),
        .mask_q  (mask_q)
    );

    baud_tick_core #(.DIV_W(DIV_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .div_q    (div_q),
        .mask_q   (mask_q),
        .os_tick  (os_tick),
        .bit_tick (bit_tick),
        .slot_idx (slot_idx)
    );
endmodule

// File: rtl/baud_slot_gen_chk.sv
// Module baud_slot_gen_chk
// Port-level protocol checks for baud_slot_gen, bound to every instance.
module baud_slot_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       os_tick,
    input logic       bit_tick,
    input logic [3:0] slot_idx
);
    // R4: a bit pulse always coincides with an oversample pulse
    a_r4_bit_with_os: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    // R4: a bit pulse only ends the last sub-bit period
    a_r4_bit_last_slot: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> (slot_idx == 4'd15));

    // R3: the slot index advances by one after each oversample pulse
    a_r3_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && en) |=> (slot_idx == 4'($past(slot_idx) + 4'd1)));

    // R3: the slot index holds between oversample pulses while running
    a_r3_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !os_tick) |=> (en -> $stable(slot_idx)));

    // R8: no pulses while disabled
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!os_tick && !bit_tick));

    // R8: a fresh start always begins at slot 0
    a_r8_start_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (slot_idx == 4'd0));
endmodule

bind baud_slot_gen baud_slot_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .os_tick  (os_tick),
    .bit_tick (bit_tick),
    .slot_idx (slot_idx)
);

// File: tb/sim_baud_slot_gen.sv
`timescale 1ns/1ps
module sim_baud_slot_gen;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [DIV_W-1:0] div_int = '0;
    logic [15:0]      slot_mask = '0;
    logic             frac_mode = 1'b0;
    logic [3:0]       frac_val = '0;
    logic             os_tick;
    logic             bit_tick;
    logic [3:0]       slot_idx;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    int          cur_div;
    logic [15:0] cur_mask;
    int          nx_div;
    logic        nx_mode;
    logic [3:0]  nx_fv;
    logic [15:0] nx_sm;
    logic [15:0] nx_exp;

    baud_slot_gen #(.DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .div_int(div_int),
        .slot_mask(slot_mask), .frac_mode(frac_mode), .frac_val(frac_val),
        .os_tick(os_tick), .bit_tick(bit_tick), .slot_idx(slot_idx)
    );

    always #4 clk = ~clk;

    // Expected helper pattern, as listed in requirement R5
    function automatic logic [15:0] exp_pat(input int f);
        case (f)
            0: return 16'h0000;   1: return 16'h0080;
            2: return 16'h0808;   3: return 16'h0888;
            4: return 16'h2222;   5: return 16'h4924;
            6: return 16'h4a52;   7: return 16'h54aa;
            8: return 16'h5555;   9: return 16'hd555;
            10: return 16'hd5d5;  11: return 16'hddd5;
            12: return 16'hdddd;  13: return 16'hdfdd;
            14: return 16'hdfdf;  default: return 16'hffdf;
        endcase
    endfunction

    function automatic int pop16(input logic [15:0] m);
        int n = 0;
        for (int i = 0; i < 16; i++) n += int'(m[i]);
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Program while idle, then start; the shadow captures the idle values
    task automatic start_cfg(input int d, input bit mode, input int fv, input logic [15:0] sm);
        @(negedge clk);
        en = 1'b0;
        div_int = DIV_W'(d); frac_mode = mode; frac_val = 4'(fv); slot_mask = sm;
        cur_div = d;
        cur_mask = mode ? exp_pat(fv) : sm;
        repeat (2) @(negedge clk);
        en = 1'b1;
    endtask

    // Measure nbits bit times; optionally reprogram at clock chg_at of bit 0
    task automatic run_bits(input int nbits, input int chg_at);
        int per = 0;
        int bitlen = 0;
        int slot = 0;
        int bits = 0;
        int guard = 0;
        bit pend = 1'b0;
        while (bits < nbits && guard < 20000) begin
            #1;
            per++; bitlen++; guard++;
            if (chg_at >= 0 && bits == 0 && bitlen == chg_at) begin
                div_int = DIV_W'(nx_div); frac_mode = nx_mode;
                frac_val = nx_fv; slot_mask = nx_sm;
                pend = 1'b1;
            end
            if (os_tick) begin
                chk(per == cur_div + 1 + int'(cur_mask[slot]), "R2 sub-period", per,
                    cur_div + 1 + int'(cur_mask[slot]));
                chk(int'(slot_idx) == slot, "R3 slot index", int'(slot_idx), slot);
                chk(bit_tick == (slot == 15), "R4 bit pulse placement", int'(bit_tick),
                    int'(slot == 15));
                if (slot == 15) begin
                    chk(bitlen == 16 * (cur_div + 1) + pop16(cur_mask),
                        chg_at >= 0 ? "R7 bit length" : "R1 bit length", bitlen,
                        16 * (cur_div + 1) + pop16(cur_mask));
                    bitlen = 0;
                    bits++;
                    if (pend) begin
                        cur_div = nx_div; cur_mask = nx_exp; pend = 1'b0;
                    end
                end
                per = 0;
                slot = (slot + 1) % 16;
            end else if (bit_tick) begin
                chk(1'b0, "R4 bit pulse without oversample", 1, 0);
            end
            @(negedge clk);
        end
        chk(bits == nbits, "R1 bits completed", bits, nbits);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks + 1);
                $finish;
            end
        end
    end

    initial begin
        int idle_ticks;
        // R9: reset state, with en low and then with en high
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!os_tick && !bit_tick && slot_idx == 0, "R9 reset idle", int'(os_tick), 0);
        en = 1'b1;
        div_int = 8'd2; slot_mask = 16'h0101;
        cur_div = 2; cur_mask = 16'h0101;
        repeat (3) begin
            @(negedge clk);
            chk(!os_tick && !bit_tick && slot_idx == 0, "R9 reset with en high",
                int'(os_tick), 0);
        end
        rst_n = 1'b1;
        run_bits(2, -1);

        // R5: every helper fraction under several divisors; slot_mask is junk
        for (int d = 0; d < 4; d += 3) begin
            for (int f = 0; f < 16; f++) begin
                start_cfg(d, 1'b1, f, 16'hA5A5 ^ 16'(f * 16'h1357));
                run_bits(2, -1);
            end
        end
        for (int f = 0; f < 16; f++) begin
            start_cfg(1, 1'b1, f, 16'hFFFF);
            run_bits(1, -1);
        end

        // R6: direct masks with a nonzero frac_val that must have no effect
        for (int d = 0; d < 7; d += 2) begin
            logic [15:0] masks [6];
            masks = '{16'h0000, 16'hFFFF, 16'h0001, 16'h8000, 16'hA5C3, 16'h7E18};
            for (int k = 0; k < 6; k++) begin
                start_cfg(d, 1'b0, 9 + k, masks[k]);
                run_bits(2, -1);
            end
        end

        // R7: mid-bit reprogram from direct mode to plain-fraction mode
        start_cfg(3, 1'b0, 0, 16'h0000);
        nx_div = 1; nx_mode = 1'b1; nx_fv = 4'd15; nx_sm = 16'h0000;
        nx_exp = exp_pat(15);
        run_bits(3, 20);
        // R7: mid-bit reprogram of the direct mask only
        start_cfg(0, 1'b0, 0, 16'hFFFF);
        nx_div = 0; nx_mode = 1'b0; nx_fv = 4'd3; nx_sm = 16'h0000;
        nx_exp = 16'h0000;
        run_bits(2, 5);

        // R8: disabled for a stretch: no pulses, slot 0
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        idle_ticks = 0;
        for (int i = 0; i < 40; i++) begin
            if (os_tick || bit_tick || slot_idx != 0) idle_ticks++;
            @(negedge clk);
        end
        chk(idle_ticks == 0, "R8 idle quiet", idle_ticks, 0);
        // R8: config captured on the last idle clock, restart from slot 0
        start_cfg(4, 1'b1, 6, 16'h0000);
        run_bits(2, -1);

        // R9: reset while running, then resume from slot 0
        start_cfg(2, 1'b0, 0, 16'h00F0);
        repeat (23) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!os_tick && slot_idx == 0, "R9 reset mid-run", int'(slot_idx), 0);
        @(negedge clk);
        rst_n = 1'b1;
        run_bits(2, -1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule